// File: doc/BRIEF.md
# Indirect Register Window for a Network Controller

This block is the host-side register window of a network controller. The host sees a handful of 16-bit word locations on a simple synchronous read/write strobe bus. One location is an index pointer. Two data locations reach the word that the pointer selects, one in the control/status file and one in the bus configuration file. A read of a fourth location soft-resets the controller. Everything behind the window is reached through the pointer: the command/status word, the init block base address, the station address, the identification pair and the descriptor style field.

The command/status word drives a small start/stop sequencer. Writing the init command raises a done flag after a fixed, parameterised latency, which models the init block fetch. The start command puts the controller into the running state. The transmit demand command produces a single-cycle poll pulse. The stop command returns everything to the idle state. The decoded configuration (init base, station address, 32-bit descriptor select, run state, poll pulse) is driven on ports for the rest of the controller.

Top module: `nic_regport`

## Requirements
- R1: Word addresses decode as follows: 8 = control/status data, 9 = index pointer, 10 = soft reset, 11 = configuration data. Every other address reads 0 and ignores writes. A read returns its data on rdata_o from the clock edge that samples rd_i, and that value holds until the next read. A write is ignored when rd_i is also high in the same cycle.
- R2: After rst_ni, and after any read of address 10, the state is: command/status word 0x0004 (stop only), pointer 0, running_o 0, tx_poll_o 0, init_base_o 0, desc32_o 0, station_addr_o = STATION_RST. The read of address 10 itself returns 0.
- R3: The pointer holds the low PTR_W (7) bits of the written word and reads back unchanged, with the bits above them read as 0 (writing 88 reads 88).
- R4: A command write (index 0) with bit 0 set sets bit 0 and clears bit 2. Bit 8 (init done) becomes set INIT_LAT cycles after the write edge. Writing bit 8 as 1 clears it. A new init write restarts the latency.
- R5: A command write with bit 1 set sets bit 1, clears bit 2 and drives running_o high. A command write with bit 3 set, while bit 2 is clear, sets bit 3 and tx_poll_o for exactly one cycle. While bit 2 is set, bit 3 writes are ignored.
- R6: A command write with bit 2 set sets bit 2, clears bits 0, 1 and 8, and cancels a pending init. It takes priority over bits 0 and 1 written in the same word. Zero bits in a command write change nothing.
- R7: Index 88 reads {PART_CODE[3:0], 12'h003} and index 89 reads {4'h0, PART_CODE[15:4]}, so together they form the 32-bit identity word {4'h0, PART_CODE, 12'h003}. Writes to them are ignored.
- R8: Indices 1 and 2 are full 16-bit read/write words, and init_base_o = {index 2, index 1}.
- R9: Indices 12, 13 and 14 are full 16-bit read/write words. station_addr_o[16k+15:16k] = index 12+k, so the low byte of each word is the earlier address byte.
- R10: Configuration index 20 stores bits 7:0 and reads bits 15:8 as 0. desc32_o is high when that field equals 2. All other control/status and configuration indices read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| addr_i | input | 4 | Word address in the window |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Registered read data |
| running_o | output | 1 | Controller in the running state |
| tx_poll_o | output | 1 | One-cycle transmit poll pulse |
| init_base_o | output | 32 | Init block base address |
| station_addr_o | output | 48 | Station address |
| desc32_o | output | 1 | 32-bit descriptor style selected |

## Verification
Read data is registered, so a read sampled at edge E reflects the state as of just before E. The bench drives each strobe at a falling edge and samples rdata_o at the next falling edge. A write's effect on running_o and tx_poll_o is visible at the falling edge after the write edge, and the poll pulse is gone one cycle later. The done flag is set at edge E0+INIT_LAT after an init write at E0. The bench therefore reads the command word at edge E0+INIT_LAT, expecting bit 8 clear, and again at E0+INIT_LAT+1, expecting it set.

// File: rtl/nic_regport_pkg.sv
package nic_regport_pkg;
  localparam logic [3:0] WA_CSR = 4'h8;
  localparam logic [3:0] WA_PTR = 4'h9;
  localparam logic [3:0] WA_RST = 4'hA;
  localparam logic [3:0] WA_BCR = 4'hB;

  localparam int unsigned IX_CTRL   = 0;
  localparam int unsigned IX_IBA_LO = 1;
  localparam int unsigned IX_IBA_HI = 2;
  localparam int unsigned IX_SA0    = 12;
  localparam int unsigned IX_ID_LO  = 88;
  localparam int unsigned IX_ID_HI  = 89;
  localparam int unsigned IX_STYLE  = 20;
  localparam int unsigned SA_WORDS  = 3;
  localparam logic [7:0]  STYLE_32  = 8'h02;

  localparam int unsigned B_INIT = 0;
  localparam int unsigned B_STRT = 1;
  localparam int unsigned B_STOP = 2;
  localparam int unsigned B_TDMD = 3;
  localparam int unsigned B_IDON = 8;

  typedef struct packed {
    logic csr_wr;
    logic bcr_wr;
    logic ptr_wr;
    logic csr_rd;
    logic bcr_rd;
    logic ptr_rd;
    logic any_rd;
    logic soft_rst;
  } win_strb_t;

  typedef struct packed {
    logic idon_clr;
    logic tdmd;
    logic stop;
    logic strt;
    logic init;
  } ctrl_cmd_t;
endpackage

// File: rtl/nic_win_decode.sv
module nic_win_decode
  import nic_regport_pkg::*;
(
  input  logic       rd_i,
  input  logic       wr_i,
  input  logic [3:0] addr_i,
  output win_strb_t  strb_o
);
  logic wr_ok;
  assign wr_ok = wr_i && !rd_i;

  always_comb begin
    strb_o          = '0;
    strb_o.any_rd   = rd_i;
    strb_o.csr_wr   = wr_ok && (addr_i == WA_CSR);
    strb_o.bcr_wr   = wr_ok && (addr_i == WA_BCR);
    strb_o.ptr_wr   = wr_ok && (addr_i == WA_PTR);
    strb_o.csr_rd   = rd_i && (addr_i == WA_CSR);
    strb_o.bcr_rd   = rd_i && (addr_i == WA_BCR);
    strb_o.ptr_rd   = rd_i && (addr_i == WA_PTR);
    strb_o.soft_rst = rd_i && (addr_i == WA_RST);
  end
endmodule

// File: rtl/nic_ctrl_fsm.sv
module nic_ctrl_fsm #(
  parameter int unsigned INIT_LAT = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     soft_rst_i,
  input  logic                     wr_i,
  input  nic_regport_pkg::ctrl_cmd_t cmd_i,
  output logic [15:0]              ctrl_o,
  output logic                     running_o,
  output logic                     tx_poll_o,
  output logic                     idon_o
);
  localparam int unsigned CNT_W = $clog2(INIT_LAT + 1);

  logic             init_q, strt_q, stop_q, tdmd_q, idon_q, busy_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      init_q <= 1'b0; strt_q <= 1'b0; stop_q <= 1'b1;
      tdmd_q <= 1'b0; idon_q <= 1'b0; busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (soft_rst_i) begin
      init_q <= 1'b0; strt_q <= 1'b0; stop_q <= 1'b1;
      tdmd_q <= 1'b0; idon_q <= 1'b0; busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      tdmd_q <= 1'b0;
      if (busy_q) begin
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CNT_W'(1)) begin
          busy_q <= 1'b0;
          idon_q <= 1'b1;
        end
      end
      if (wr_i) begin
        if (cmd_i.stop) begin
          stop_q <= 1'b1; init_q <= 1'b0; strt_q <= 1'b0;
          idon_q <= 1'b0; busy_q <= 1'b0; cnt_q  <= '0;
        end else begin
          if (cmd_i.init) begin
            init_q <= 1'b1; stop_q <= 1'b0;
            busy_q <= 1'b1; cnt_q  <= CNT_W'(INIT_LAT);
          end
          if (cmd_i.strt) begin
            strt_q <= 1'b1; stop_q <= 1'b0;
          end
          if (cmd_i.tdmd && !stop_q) tdmd_q <= 1'b1;
          if (cmd_i.idon_clr) idon_q <= 1'b0;
        end
      end
    end
  end

  assign ctrl_o    = {7'b0, idon_q, 4'b0, tdmd_q, stop_q, strt_q, init_q};
  assign running_o = strt_q;
  assign tx_poll_o = tdmd_q;
  assign idon_o    = idon_q;
endmodule

// File: rtl/nic_reg_bank.sv
module nic_reg_bank
  import nic_regport_pkg::*;
#(
  parameter int unsigned PTR_W       = 7,
  parameter logic [15:0] PART_CODE   = 16'h2625,
  parameter logic [47:0] STATION_RST = 48'h5F4E3D2C1B0A
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             soft_rst_i,
  input  logic             csr_wr_i,
  input  logic             bcr_wr_i,
  input  logic [PTR_W-1:0] ptr_i,
  input  logic [15:0]      wdata_i,
  output logic [15:0]      csr_rdata_o,
  output logic [15:0]      bcr_rdata_o,
  output logic [31:0]      init_base_o,
  output logic [47:0]      station_addr_o,
  output logic             desc32_o
);
  localparam logic [31:0] ID_WORD = {4'h0, PART_CODE, 12'h003};

  logic [31:0] ix;
  logic [15:0] iba_lo_q, iba_hi_q;
  logic [7:0]  style_q;
  logic [16*SA_WORDS-1:0] sa_all;

  assign ix = 32'(ptr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      iba_lo_q <= '0; iba_hi_q <= '0; style_q <= '0;
    end else if (soft_rst_i) begin
      iba_lo_q <= '0; iba_hi_q <= '0; style_q <= '0;
    end else begin
      if (csr_wr_i && ix == IX_IBA_LO) iba_lo_q <= wdata_i;
      if (csr_wr_i && ix == IX_IBA_HI) iba_hi_q <= wdata_i;
      if (bcr_wr_i && ix == IX_STYLE)  style_q  <= wdata_i[7:0];
    end
  end

  for (genvar g = 0; g < SA_WORDS; g++) begin : g_sa
    logic [15:0] word_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               word_q <= STATION_RST[16*g +: 16];
      else if (soft_rst_i)                       word_q <= STATION_RST[16*g +: 16];
      else if (csr_wr_i && ix == IX_SA0 + g)     word_q <= wdata_i;
    end
    assign sa_all[16*g +: 16] = word_q;
  end

  always_comb begin
    csr_rdata_o = '0;
    if (ix == IX_IBA_LO) csr_rdata_o = iba_lo_q;
    if (ix == IX_IBA_HI) csr_rdata_o = iba_hi_q;
    if (ix == IX_ID_LO)  csr_rdata_o = ID_WORD[15:0];
    if (ix == IX_ID_HI)  csr_rdata_o = ID_WORD[31:16];
    for (int k = 0; k < SA_WORDS; k++) begin
      if (ix == IX_SA0 + k) csr_rdata_o = sa_all[16*k +: 16];
    end
    bcr_rdata_o = (ix == IX_STYLE) ? {8'h00, style_q} : 16'h0000;
  end

  assign init_base_o    = {iba_hi_q, iba_lo_q};
  assign station_addr_o = sa_all;
  assign desc32_o       = (style_q == STYLE_32);
endmodule

// File: rtl/nic_regport.sv
module nic_regport
  import nic_regport_pkg::*;
#(
  parameter int unsigned PTR_W       = 7,
  parameter int unsigned INIT_LAT    = 8,
  parameter logic [15:0] PART_CODE   = 16'h2625,
  parameter logic [47:0] STATION_RST = 48'h5F4E3D2C1B0A
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        rd_i,
  input  logic        wr_i,
  input  logic [3:0]  addr_i,
  input  logic [15:0] wdata_i,
  output logic [15:0] rdata_o,
  output logic        running_o,
  output logic        tx_poll_o,
  output logic [31:0] init_base_o,
  output logic [47:0] station_addr_o,
  output logic        desc32_o
);
  win_strb_t        strb;
  ctrl_cmd_t        cmd;
  logic [PTR_W-1:0] ptr_q;
  logic [15:0]      ctrl_word, csr_rdata, bcr_rdata, rdata_q;
  logic             ctrl_sel, idon;

  nic_win_decode u_dec (
    .rd_i(rd_i), .wr_i(wr_i), .addr_i(addr_i), .strb_o(strb)
  );

  assign ctrl_sel     = (32'(ptr_q) == IX_CTRL);
  assign cmd.init     = wdata_i[B_INIT];
  assign cmd.strt     = wdata_i[B_STRT];
  assign cmd.stop     = wdata_i[B_STOP];
  assign cmd.tdmd     = wdata_i[B_TDMD];
  assign cmd.idon_clr = wdata_i[B_IDON];

  nic_ctrl_fsm #(.INIT_LAT(INIT_LAT)) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .soft_rst_i(strb.soft_rst),
    .wr_i(strb.csr_wr && ctrl_sel), .cmd_i(cmd), .ctrl_o(ctrl_word),
    .running_o(running_o), .tx_poll_o(tx_poll_o), .idon_o(idon)
  );

  nic_reg_bank #(
    .PTR_W(PTR_W), .PART_CODE(PART_CODE), .STATION_RST(STATION_RST)
  ) u_bank (
    .clk_i(clk_i), .rst_ni(rst_ni), .soft_rst_i(strb.soft_rst),
    .csr_wr_i(strb.csr_wr), .bcr_wr_i(strb.bcr_wr), .ptr_i(ptr_q),
    .wdata_i(wdata_i), .csr_rdata_o(csr_rdata), .bcr_rdata_o(bcr_rdata),
    .init_base_o(init_base_o), .station_addr_o(station_addr_o),
    .desc32_o(desc32_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            ptr_q <= '0;
    else if (strb.soft_rst) ptr_q <= '0;
    else if (strb.ptr_wr)   ptr_q <= wdata_i[PTR_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            rdata_q <= '0;
    else if (strb.soft_rst) rdata_q <= '0;
    else if (strb.csr_rd)   rdata_q <= ctrl_sel ? ctrl_word : csr_rdata;
    else if (strb.bcr_rd)   rdata_q <= bcr_rdata;
    else if (strb.ptr_rd)   rdata_q <= {{(16-PTR_W){1'b0}}, ptr_q};
    else if (strb.any_rd)   rdata_q <= '0;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/nic_regport_chk.sv
module nic_regport_chk
  import nic_regport_pkg::*;
#(
  parameter int unsigned PTR_W     = 7,
  parameter int unsigned INIT_LAT  = 8,
  parameter logic [15:0] PART_CODE = 16'h2625
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             rd_i,
  input logic             wr_i,
  input logic [3:0]       addr_i,
  input logic [15:0]      wdata_i,
  input logic [15:0]      rdata_o,
  input logic             running_o,
  input logic             tx_poll_o,
  input logic [PTR_W-1:0] ptr_i,
  input logic             idon_i
);
  localparam int unsigned CW       = $clog2(INIT_LAT + 2);
  localparam logic [15:0] PTR_MASK = 16'((1 << PTR_W) - 1);
  localparam logic [15:0] ID_LO    = {PART_CODE[3:0], 12'h003};

  logic          ctl_wr, init_wr, stop_wr, clr_wr, tdmd_wr, rst_rd, wait_q;
  logic [CW-1:0] cnt_q;

  assign ctl_wr  = wr_i && !rd_i && addr_i == WA_CSR && 32'(ptr_i) == IX_CTRL;
  assign stop_wr = ctl_wr && wdata_i[B_STOP];
  assign init_wr = ctl_wr && wdata_i[B_INIT] && !wdata_i[B_STOP];
  assign clr_wr  = ctl_wr && (wdata_i[B_IDON] || wdata_i[B_STOP]);
  assign tdmd_wr = ctl_wr && wdata_i[B_TDMD];
  assign rst_rd  = rd_i && addr_i == WA_RST;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wait_q <= 1'b0; cnt_q <= '0;
    end else if (rst_rd || stop_wr) begin
      wait_q <= 1'b0;
    end else if (init_wr) begin
      wait_q <= 1'b1; cnt_q <= CW'(INIT_LAT);
    end else if (wait_q) begin
      cnt_q <= cnt_q - 1'b1;
      if (cnt_q == CW'(1)) wait_q <= 1'b0;
    end
  end

  p_unmapped_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && (addr_i < 4'h8 || addr_i > 4'hB)) |=> rdata_o == 16'h0000);

  p_reset_port_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_rd |=> (!running_o && !tx_poll_o && rdata_o == 16'h0000));

  p_ptr_readback_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !rd_i && addr_i == WA_PTR) ##1 (rd_i && addr_i == WA_PTR)
    |=> rdata_o == ($past(wdata_i, 2) & PTR_MASK));

  p_idon_due_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wait_q && cnt_q == CW'(1) && !clr_wr && !rst_rd) |=> idon_i);

  p_idon_origin_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(idon_i) |-> $past(wait_q && cnt_q == CW'(1)));

  p_start_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(running_o) |-> $past(ctl_wr && wdata_i[B_STRT] && !wdata_i[B_STOP]));

  p_poll_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_poll_o && !tdmd_wr) |=> !tx_poll_o);

  p_stop_halts_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_wr |=> (!running_o && !idon_i));

  p_id_lo_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == WA_CSR && 32'(ptr_i) == IX_ID_LO) |=> rdata_o == ID_LO);
endmodule

bind nic_regport nic_regport_chk #(
  .PTR_W(PTR_W), .INIT_LAT(INIT_LAT), .PART_CODE(PART_CODE)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .rd_i(rd_i), .wr_i(wr_i),
  .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
  .running_o(running_o), .tx_poll_o(tx_poll_o),
  .ptr_i(ptr_q), .idon_i(idon)
);

// File: tb/nic_regport_tb.sv
`timescale 1ns/1ps
module nic_regport_tb;
  localparam int unsigned PTR_W       = 7;
  localparam int unsigned INIT_LAT    = 8;
  localparam logic [15:0] PART_CODE   = 16'h2625;
  localparam logic [47:0] STATION_RST = 48'h5F4E3D2C1B0A;
  localparam logic [3:0]  A_CSR = 4'h8, A_PTR = 4'h9, A_RST = 4'hA, A_BCR = 4'hB;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        rd_i = 1'b0, wr_i = 1'b0;
  logic [3:0]  addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic        running_o, tx_poll_o, desc32_o;
  logic [31:0] init_base_o;
  logic [47:0] station_addr_o;

  int checks = 0;
  int failures = 0;

  always #2.5 clk_i = ~clk_i;

  nic_regport #(
    .PTR_W(PTR_W), .INIT_LAT(INIT_LAT), .PART_CODE(PART_CODE), .STATION_RST(STATION_RST)
  ) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .rd_i(rd_i), .wr_i(wr_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .running_o(running_o),
    .tx_poll_o(tx_poll_o), .init_base_o(init_base_o),
    .station_addr_o(station_addr_o), .desc32_o(desc32_o)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    @(posedge clk_i); @(negedge clk_i);
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [15:0] d);
    wr_i = 1'b1; addr_i = a; wdata_i = d;
    idle();
    wr_i = 1'b0;
  endtask

  task automatic rd_reg(input logic [3:0] a, output logic [15:0] d);
    rd_i = 1'b1; addr_i = a;
    idle();
    rd_i = 1'b0;
    d = rdata_o;
  endtask

  function automatic logic [15:0] pat(input int idx);
    return 16'hA5C3 ^ 16'(idx * 257);
  endfunction

  function automatic logic [15:0] exp_csr(input int idx, input logic [15:0] v);
    case (idx)
      1, 2, 12, 13, 14: return v;
      88: return {PART_CODE[3:0], 12'h003};
      89: return {4'h0, PART_CODE[15:4]};
      default: return 16'h0000;
    endcase
  endfunction

  initial begin
    #1000000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    idle();

    // R2 reset state
    chk("R2 running", 64'(running_o), 64'd0);
    chk("R2 poll", 64'(tx_poll_o), 64'd0);
    chk("R2 station", 64'(station_addr_o), 64'(STATION_RST));
    chk("R2 base", 64'(init_base_o), 64'd0);
    chk("R2 desc32", 64'(desc32_o), 64'd0);
    rd_reg(A_CSR, d); chk("R2 csr0", 64'(d), 64'h0004);
    rd_reg(A_PTR, d); chk("R3 ptr reset", 64'(d), 64'd0);

    // R3 pointer sweep
    for (int i = 0; i < 128; i++) begin
      wr_reg(A_PTR, 16'hFF80 | 16'(i));
      rd_reg(A_PTR, d);
      chk("R3 ptr", 64'(d), 64'(i));
    end

    // R7 R8 R9 R10 control/status index sweep
    for (int i = 1; i < 128; i++) begin
      wr_reg(A_PTR, 16'(i));
      wr_reg(A_CSR, pat(i));
      rd_reg(A_CSR, d);
      chk("R10 csr sweep", 64'(d), 64'(exp_csr(i, pat(i))));
    end
    chk("R8 base", 64'(init_base_o), 64'({pat(2), pat(1)}));
    chk("R9 station", 64'(station_addr_o), 64'({pat(14), pat(13), pat(12)}));
    wr_reg(A_PTR, 16'd12); wr_reg(A_CSR, 16'hBBAA);
    chk("R9 byte order", 64'(station_addr_o[15:0]), 64'h0000_BBAA);

    // R10 configuration index sweep
    for (int i = 0; i < 128; i++) begin
      wr_reg(A_PTR, 16'(i));
      wr_reg(A_BCR, pat(i));
      rd_reg(A_BCR, d);
      chk("R10 bcr sweep", 64'(d), (i == 20) ? 64'(pat(i) & 16'h00FF) : 64'd0);
    end
    wr_reg(A_PTR, 16'd20);
    wr_reg(A_BCR, 16'hFF02); chk("R10 desc32 on", 64'(desc32_o), 64'd1);
    wr_reg(A_BCR, 16'h0003); chk("R10 desc32 off", 64'(desc32_o), 64'd0);

    // R1 unmapped addresses and read/write collision
    wr_reg(A_PTR, 16'd33);
    for (int a = 0; a < 16; a++) begin
      if (a < 8 || a > 11) begin
        wr_reg(4'(a), 16'hFFFF);
        rd_reg(4'(a), d);
        chk("R1 unmapped", 64'(d), 64'd0);
      end
    end
    rd_reg(A_PTR, d); chk("R1 ptr untouched", 64'(d), 64'd33);
    rd_i = 1'b1; wr_i = 1'b1; addr_i = A_PTR; wdata_i = 16'd77;
    idle();
    rd_i = 1'b0; wr_i = 1'b0;
    chk("R1 collide read", 64'(rdata_o), 64'd33);
    rd_reg(A_PTR, d); chk("R1 collide write", 64'(d), 64'd33);

    // R4 init latency boundary
    wr_reg(A_PTR, 16'd0);
    wr_reg(A_CSR, 16'h0001);
    rd_reg(A_CSR, d); chk("R4 init set", 64'(d), 64'h0001);
    repeat (INIT_LAT - 2) idle();
    rd_reg(A_CSR, d); chk("R4 not yet done", 64'(d), 64'h0001);
    rd_reg(A_CSR, d); chk("R4 done", 64'(d), 64'h0101);
    wr_reg(A_CSR, 16'h0100);
    rd_reg(A_CSR, d); chk("R4 done clear", 64'(d), 64'h0001);
    wr_reg(A_CSR, 16'h0001);
    repeat (INIT_LAT + 2) idle();
    rd_reg(A_CSR, d); chk("R4 re-init done", 64'(d), 64'h0101);

    // R5 start and transmit demand
    wr_reg(A_CSR, 16'h0002);
    chk("R5 running", 64'(running_o), 64'd1);
    rd_reg(A_CSR, d); chk("R5 csr0 run", 64'(d), 64'h0103);
    wr_reg(A_CSR, 16'h0008);
    chk("R5 poll high", 64'(tx_poll_o), 64'd1);
    idle();
    chk("R5 poll low", 64'(tx_poll_o), 64'd0);
    rd_reg(A_CSR, d); chk("R5 poll cleared", 64'(d), 64'h0103);

    // R6 stop priority, ignored commands
    wr_reg(A_CSR, 16'h0007);
    chk("R6 stopped", 64'(running_o), 64'd0);
    rd_reg(A_CSR, d); chk("R6 csr0 stop", 64'(d), 64'h0004);
    wr_reg(A_CSR, 16'h0008);
    chk("R5 poll while stopped", 64'(tx_poll_o), 64'd0);
    rd_reg(A_CSR, d); chk("R5 csr0 stopped", 64'(d), 64'h0004);
    wr_reg(A_CSR, 16'h0000);
    rd_reg(A_CSR, d); chk("R6 zero write", 64'(d), 64'h0004);
    wr_reg(A_CSR, 16'h0001);
    wr_reg(A_CSR, 16'h0004);
    repeat (INIT_LAT + 2) idle();
    rd_reg(A_CSR, d); chk("R6 init cancelled", 64'(d), 64'h0004);

    // R2 soft reset through the window
    wr_reg(A_CSR, 16'h0002);
    wr_reg(A_PTR, 16'd1); wr_reg(A_CSR, 16'h1234);
    wr_reg(A_PTR, 16'd20); wr_reg(A_BCR, 16'h0002);
    chk("R2 pre running", 64'(running_o), 64'd1);
    rd_reg(A_RST, d); chk("R2 reset read", 64'(d), 64'd0);
    chk("R2 soft running", 64'(running_o), 64'd0);
    chk("R2 soft station", 64'(station_addr_o), 64'(STATION_RST));
    chk("R2 soft base", 64'(init_base_o), 64'd0);
    chk("R2 soft desc32", 64'(desc32_o), 64'd0);
    rd_reg(A_PTR, d); chk("R2 soft ptr", 64'(d), 64'd0);
    rd_reg(A_CSR, d); chk("R2 soft csr0", 64'(d), 64'h0004);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule